// File: doc/BRIEF.md
# External Interrupt Pending and Mask Controller

This block gathers external interrupt requests for one processor core. Any master on the memory-mapped bus posts an interrupt by writing an interrupt number to a single 32-bit port. The number is stored in reversed order: interrupt 0 sets the most significant pending bit and interrupt 31 sets bit 0. A timer alarm strobe posts interrupt 0 in the same way. The core side can clear pending bits by writing ones, and it can replace the enable mask in one write. The block drives a hard request line whenever an enabled interrupt is pending.

An acceptance stage sits behind the request line. When the core reaches a point where it can take an interruption, the stage picks between a latched non-maskable request and the maskable external request. The non-maskable request always wins. The external request is gated by the core's interrupt-enable status bit. A non-maskable request stays latched until it is taken once.

The asynchronous active-low reset is released through a two-stage synchronizer. Register state therefore leaves reset two clock edges after `rst_n` rises.

Top module: `xirq_ctrl`

## Requirements
- R1: A full-width bus write with data d sets pending bit number 31 − d[4:0]. Data bits 31..5 are ignored, and other pending bits keep their value unless another source in the same cycle changes them.
- R2: A bus write with `bus_be` not equal to 4'b1111 leaves the pending register unchanged.
- R3: `bus_rdata` equals the pending register while `bus_rd_en` is high with `bus_be` = 4'b1111. In every other cycle it is zero.
- R4: A core clear write with value v clears every pending bit where v is 1 and leaves the other bits unchanged.
- R5: A core mask write replaces all 32 mask bits with `core_mask_data`.
- R6: `irq_req` is high exactly when the pending and mask registers share a set bit. It reflects an update from the cycle after that update.
- R7: A `timer_alarm` strobe sets pending bit 31, the same as a bus write of data 0. It combines with a bus post in the same cycle.
- R8: If a core clear and a post hit the same bit in the same cycle, the bit ends up set.
- R9: `take_ext` is high only when `accept_en`, `psw_ie` and `irq_req` are all high and no non-maskable request is latched.
- R10: An `nmi_req` strobe is latched. While it is latched and `accept_en` is high, `take_nmi` is asserted instead of `take_ext`. Acceptance clears the latch, so one strobe produces one acceptance.
- R11: Reset clears the pending register, the mask register and the non-maskable latch, so `irq_req`, `take_nmi` and `take_ext` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Bus write strobe to the post port |
| bus_rd_en | input | 1 | Bus read strobe to the post port |
| bus_be | input | 4 | Byte enables; only 4'b1111 is a valid access |
| bus_wdata | input | 32 | Bus write data; bits 4..0 carry the interrupt number |
| bus_rdata | output | 32 | Bus read data (pending register) |
| timer_alarm | input | 1 | Timer strobe that posts interrupt 0 |
| core_clr_en | input | 1 | Core write-ones-to-clear strobe for pending bits |
| core_clr_data | input | 32 | Bits to clear |
| core_mask_en | input | 1 | Core mask load strobe |
| core_mask_data | input | 32 | New mask value |
| psw_ie | input | 1 | Core status interrupt-enable bit |
| nmi_req | input | 1 | Non-maskable request strobe |
| accept_en | input | 1 | Core can take an interruption this cycle |
| pending_o | output | 32 | Current pending register |
| mask_o | output | 32 | Current mask register |
| irq_req | output | 1 | Hard request: an enabled interrupt is pending |
| take_nmi | output | 1 | Non-maskable request accepted this cycle |
| take_ext | output | 1 | External interrupt accepted this cycle |

## Verification
The hardest situation to reach is a single edge where a bus post, a timer strobe and a core clear all touch the same pending bits, especially bit 31, which both posting sources can hit. Directed steps put these collisions into one cycle on purpose. A long random phase then drives all strobes at once with narrow data values, so overlaps happen often. A second hard case is a non-maskable strobe that arrives in the same cycle it is being accepted. The random phase keeps `accept_en` and `nmi_req` active together often enough to produce it, and the per-cycle reference model catches a lost or doubled acceptance.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int unsigned IRQ_W   = 32;
  localparam int unsigned IDX_W   = $clog2(IRQ_W);
  localparam int unsigned BE_W    = IRQ_W / 8;
  localparam int unsigned TMR_BIT = IRQ_W - 1;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_NMI  = 2'd1,
    ACC_EXT  = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/xirq_rst_sync.sv
module xirq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/xirq_post_decode.sv
module xirq_post_decode
  import xirq_pkg::*;
(
  input  logic             bus_post,
  input  logic [IDX_W-1:0] post_num,
  input  logic             timer_alarm,
  output logic [IRQ_W-1:0] set_vec
);
  // interrupt number n lands in bit (IRQ_W-1-n): reversed order
  for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
    localparam logic [IDX_W-1:0] NUM = IDX_W'(IRQ_W - 1 - i);
    if (i == TMR_BIT) begin : g_tmr
      assign set_vec[i] = (bus_post && (post_num == NUM)) || timer_alarm;
    end else begin : g_plain
      assign set_vec[i] = bus_post && (post_num == NUM);
    end
  end
endmodule

// File: rtl/xirq_pend_regs.sv
module xirq_pend_regs
  import xirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] set_vec,
  input  logic             clr_en,
  input  logic [IRQ_W-1:0] clr_data,
  input  logic             mask_en,
  input  logic [IRQ_W-1:0] mask_data,
  output logic [IRQ_W-1:0] pend_q,
  output logic [IRQ_W-1:0] mask_q
);
  logic [IRQ_W-1:0] pend_d, mask_d, clr_vec;
  logic             pend_ce;

  always_comb begin
    clr_vec = clr_en ? clr_data : '0;
    pend_ce = clr_en || (|set_vec);
    // clear first, set last: a post in the same cycle survives
    pend_d  = (pend_q & ~clr_vec) | set_vec;
    mask_d  = mask_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_ce) pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end
endmodule

// File: rtl/xirq_accept.sv
module xirq_accept
  import xirq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hard_req,
  input  logic      psw_ie,
  input  logic      nmi_req,
  input  logic      accept_en,
  output acc_kind_e kind
);
  logic nmi_q, nmi_d, nmi_ce;

  always_comb begin
    kind = ACC_NONE;
    if (accept_en) begin
      if (nmi_q)                  kind = ACC_NMI;
      else if (psw_ie && hard_req) kind = ACC_EXT;
    end
    nmi_ce = nmi_req || (kind == ACC_NMI);
    nmi_d  = nmi_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      nmi_q <= 1'b0;
    else if (nmi_ce) nmi_q <= nmi_d;
  end
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr_en,
  input  logic             bus_rd_en,
  input  logic [BE_W-1:0]  bus_be,
  input  logic [IRQ_W-1:0] bus_wdata,
  output logic [IRQ_W-1:0] bus_rdata,
  input  logic             timer_alarm,
  input  logic             core_clr_en,
  input  logic [IRQ_W-1:0] core_clr_data,
  input  logic             core_mask_en,
  input  logic [IRQ_W-1:0] core_mask_data,
  input  logic             psw_ie,
  input  logic             nmi_req,
  input  logic             accept_en,
  output logic [IRQ_W-1:0] pending_o,
  output logic [IRQ_W-1:0] mask_o,
  output logic             irq_req,
  output logic             take_nmi,
  output logic             take_ext
);
  logic             rst_n_int;
  logic             full_acc, bus_post;
  logic [IRQ_W-1:0] set_vec, pend_q, mask_q;
  acc_kind_e        kind;

  xirq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  assign full_acc = &bus_be;
  assign bus_post = bus_wr_en && full_acc;

  xirq_post_decode u_dec (
    .bus_post(bus_post), .post_num(bus_wdata[IDX_W-1:0]),
    .timer_alarm(timer_alarm), .set_vec(set_vec)
  );

  xirq_pend_regs u_regs (
    .clk(clk), .rst_n(rst_n_int), .set_vec(set_vec),
    .clr_en(core_clr_en), .clr_data(core_clr_data),
    .mask_en(core_mask_en), .mask_data(core_mask_data),
    .pend_q(pend_q), .mask_q(mask_q)
  );

  assign irq_req = |(pend_q & mask_q);

  xirq_accept u_acc (
    .clk(clk), .rst_n(rst_n_int), .hard_req(irq_req), .psw_ie(psw_ie),
    .nmi_req(nmi_req), .accept_en(accept_en), .kind(kind)
  );

  assign take_nmi  = (kind == ACC_NMI);
  assign take_ext  = (kind == ACC_EXT);
  assign bus_rdata = (bus_rd_en && full_acc) ? pend_q : '0;
  assign pending_o = pend_q;
  assign mask_o    = mask_q;
endmodule

// File: rtl/xirq_ctrl_chk.sv
module xirq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr_en,
  input logic [3:0]  bus_be,
  input logic [31:0] bus_wdata,
  input logic        timer_alarm,
  input logic        core_clr_en,
  input logic [31:0] core_clr_data,
  input logic        core_mask_en,
  input logic [31:0] core_mask_data,
  input logic        psw_ie,
  input logic        nmi_req,
  input logic        accept_en,
  input logic [31:0] pending_o,
  input logic [31:0] mask_o,
  input logic        irq_req,
  input logic        take_nmi,
  input logic        take_ext
);
  assert_post_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_be == 4'hF) |=> pending_o[5'(~$past(bus_wdata[4:0]))]);

  assert_partial_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_be != 4'hF && !timer_alarm && !core_clr_en)
    |=> pending_o == $past(pending_o));

  assert_clear_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clr_en && !bus_wr_en && !timer_alarm)
    |=> (pending_o & $past(core_clr_data)) == 32'h0);

  assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    core_mask_en |=> mask_o == $past(core_mask_data));

  assert_req_needs_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (pending_o != 32'h0 && mask_o != 32'h0));

  assert_timer_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timer_alarm |=> pending_o[31]);

  assert_ext_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take_ext |-> (accept_en && psw_ie && irq_req));

  assert_one_kind_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({take_nmi, take_ext}) <= 1);

  assert_nmi_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take_nmi && !nmi_req) |=> !take_nmi);
endmodule

bind xirq_ctrl xirq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_be(bus_be),
  .bus_wdata(bus_wdata), .timer_alarm(timer_alarm),
  .core_clr_en(core_clr_en), .core_clr_data(core_clr_data),
  .core_mask_en(core_mask_en), .core_mask_data(core_mask_data),
  .psw_ie(psw_ie), .nmi_req(nmi_req), .accept_en(accept_en),
  .pending_o(pending_o), .mask_o(mask_o), .irq_req(irq_req),
  .take_nmi(take_nmi), .take_ext(take_ext)
);

// File: tb/xirq_ctrl_tb.sv
module xirq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr_en, bus_rd_en, timer_alarm, core_clr_en, core_mask_en;
  logic        psw_ie, nmi_req, accept_en;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata, core_clr_data, core_mask_data;
  logic [31:0] bus_rdata, pending_o, mask_o;
  logic        irq_req, take_nmi, take_ext;

  int unsigned n_chk = 0, n_err = 0;
  bit          done = 0;
  logic [31:0] m_pend, m_mask;
  bit          m_nmi;

  always #2 clk = ~clk;

  xirq_ctrl u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    bus_wr_en = 0; bus_rd_en = 0; bus_be = 4'hF; bus_wdata = '0;
    timer_alarm = 0; core_clr_en = 0; core_clr_data = '0;
    core_mask_en = 0; core_mask_data = '0; nmi_req = 0; accept_en = 0;
  endtask

  // compare at current inputs, advance model and DUT by one edge
  task automatic cyc();
    logic [31:0] set_v, clr_v;
    bit e_irq, e_nmi, e_ext;
    #1;
    if (!rst_n) begin m_pend = '0; m_mask = '0; m_nmi = 0; end
    e_irq = (m_pend & m_mask) != 0;
    e_nmi = accept_en && m_nmi;
    e_ext = accept_en && !m_nmi && psw_ie && e_irq;
    chk("R1/R4/R7/R8 pending", pending_o, m_pend);
    chk("R5 mask", mask_o, m_mask);
    chk("R6 irq_req", 32'(irq_req), 32'(e_irq));
    chk("R3 bus_rdata", bus_rdata, (bus_rd_en && bus_be == 4'hF) ? m_pend : 32'h0);
    chk("R10 take_nmi", 32'(take_nmi), 32'(e_nmi));
    chk("R9 take_ext", 32'(take_ext), 32'(e_ext));
    if (rst_n) begin
      set_v = '0;
      if (bus_wr_en && bus_be == 4'hF) set_v[31 - int'(bus_wdata[4:0])] = 1'b1;
      if (timer_alarm) set_v[31] = 1'b1;
      clr_v = core_clr_en ? core_clr_data : 32'h0;
      m_pend = (m_pend & ~clr_v) | set_v;
      if (core_mask_en) m_mask = core_mask_data;
      m_nmi = (m_nmi && !e_nmi) || nmi_req;
    end
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic post(logic [31:0] d);
    bus_wr_en = 1; bus_wdata = d; cyc();
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    report();
  end

  initial begin
    idle(); psw_ie = 0; rst_n = 0;
    m_pend = '0; m_mask = '0; m_nmi = 0;
    @(negedge clk);
    cyc(); cyc();
    chk("R11 reset pending", pending_o, 32'h0);
    chk("R11 reset irq", 32'(irq_req), 32'h0);
    rst_n = 1;
    repeat (3) cyc();

    // R1: reversed numbering, upper data bits ignored
    post(32'h0000_0005);
    chk("R1 post 5 -> bit 26", pending_o, 32'h0400_0000);
    post(32'hFFFF_FFE3);
    chk("R1 upper bits ignored -> bit 28", pending_o, 32'h1400_0000);
    // R2: partial access ignored
    bus_wr_en = 1; bus_be = 4'h7; bus_wdata = 32'h1; cyc();
    chk("R2 partial write ignored", pending_o, 32'h1400_0000);
    // R3: read full vs partial
    bus_rd_en = 1; #1 chk("R3 full read", bus_rdata, 32'h1400_0000); cyc();
    bus_rd_en = 1; bus_be = 4'h3; #1 chk("R3 partial read", bus_rdata, 32'h0); cyc();
    // R5 / R6
    chk("R6 no mask no req", 32'(irq_req), 32'h0);
    core_mask_en = 1; core_mask_data = 32'h0400_0000; cyc();
    chk("R5 mask loaded", mask_o, 32'h0400_0000);
    chk("R6 request up", 32'(irq_req), 32'h1);
    // R9: gating by psw_ie
    accept_en = 1; #1 chk("R9 ie low no take", 32'(take_ext), 32'h0); cyc();
    psw_ie = 1; accept_en = 1; #1 chk("R9 ie high take", 32'(take_ext), 32'h1); cyc();
    // R4: write ones to clear
    core_clr_en = 1; core_clr_data = 32'h0400_0001; cyc();
    chk("R4 clear bit 26", pending_o, 32'h1000_0000);
    chk("R6 request down", 32'(irq_req), 32'h0);
    // R8: clear and post same bit in one cycle
    bus_wr_en = 1; bus_wdata = 32'h3; core_clr_en = 1; core_clr_data = 32'hFFFF_FFFF; cyc();
    chk("R8 set wins over clear", pending_o, 32'h1000_0000);
    // R7: timer, alone and with a bus post
    timer_alarm = 1; cyc();
    chk("R7 timer sets bit 31", pending_o, 32'h9000_0000);
    core_clr_en = 1; core_clr_data = 32'hFFFF_FFFF; cyc();
    timer_alarm = 1; bus_wr_en = 1; bus_wdata = 32'h1F; cyc();
    chk("R7 timer plus post 31", pending_o, 32'h8000_0001);
    // R10: nmi priority and single acceptance
    core_mask_en = 1; core_mask_data = 32'hFFFF_FFFF; cyc();
    nmi_req = 1; cyc();
    accept_en = 1; #1 chk("R10 nmi first", {take_nmi, take_ext}, 32'h2); cyc();
    accept_en = 1; #1 chk("R10 nmi taken once", {take_nmi, take_ext}, 32'h1); cyc();
    nmi_req = 1; accept_en = 1; cyc();
    accept_en = 1; nmi_req = 1; #1 chk("R10 nmi relatched", 32'(take_nmi), 32'h1); cyc();
    accept_en = 1; #1 chk("R10 second strobe taken", 32'(take_nmi), 32'h1); cyc();

    // random mix, narrow values so strobes collide
    for (int k = 0; k < 400; k++) begin
      bus_wr_en = $urandom_range(0, 1) == 1;
      bus_rd_en = $urandom_range(0, 1) == 1;
      bus_be = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'hF;
      bus_wdata = $urandom;
      timer_alarm = $urandom_range(0, 5) == 0;
      core_clr_en = $urandom_range(0, 3) == 0;
      core_clr_data = $urandom & $urandom;
      core_mask_en = $urandom_range(0, 7) == 0;
      core_mask_data = $urandom;
      nmi_req = $urandom_range(0, 7) == 0;
      accept_en = $urandom_range(0, 1) == 1;
      psw_ie = $urandom_range(0, 1) == 1;
      cyc();
    end

    // R11: reset mid-run
    rst_n = 0; cyc(); cyc();
    chk("R11 mask cleared", mask_o, 32'h0);
    chk("R11 pending cleared", pending_o, 32'h0);
    accept_en = 1; #1 chk("R11 no take", {take_nmi, take_ext}, 32'h0);
    rst_n = 1; repeat (3) cyc();
    post(32'h0);
    chk("R1 post after reset", pending_o, 32'h8000_0000);
    report();
  end
endmodule